// File: doc/BRIEF.md
# T1 Ones-Density Violation Monitor

This block watches a received unipolar T1 bit stream and reports ones-density violations. Each bit arrives with a one-cycle enable taken from the recovered line clock. Two rules are checked on every bit at the same time. The first rule fires on a run of 16 zero bits. The second rule fires when, for any N from 1 to 23, the most recent 8(N+1) bits hold fewer than N ones.

Each violation flips a status bit, so software can count events by watching for changes. A sticky interrupt bit sets on a violation unless the interrupt mask is raised. A host read strobe clears the sticky bit.

After each violation both rules start over. The run counter returns to zero, and each window rule waits until it has seen a full window of new bits. The bit history itself is kept.

Top module: `pdv_monitor`

## Requirements
- R1: A zero bit that completes a run of 16 consecutive zero bits is a violation.
- R2: For each N in 1..23, a bit is a violation when the last 8(N+1) bits (the new bit included) contain fewer than N ones. A window is judged only once 8(N+1) bits have arrived since reset or since the last violation.
- R3: `pdv_status` inverts once for each violation and holds otherwise. It changes on the clock edge that samples the bit with `bit_en` high.
- R4: `pdv_irq` goes to 1 on that same edge for a violation seen while `irq_mask` is 0. It stays at 1 until an edge where `rd_clr` is 1.
- R5: While `irq_mask` is 1, a violation still inverts `pdv_status` but does not set `pdv_irq`.
- R6: When `rd_clr` is 1 in the same cycle as an unmasked violation, `pdv_irq` ends that cycle at 1.
- R7: After a violation, the zero-run count and the window fill start again from zero. An all-zeros stream therefore gives one violation every 16 bits.
- R8: Reset sets `pdv_status` and `pdv_irq` to 0 and empties the history. After reset, no violation occurs before the 16th bit.
- R9: In cycles with `bit_en` at 0, `bit_in` is ignored and no state changes.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bit_en | input | 1 | One-cycle strobe: a received bit is valid this cycle |
| bit_in | input | 1 | Received unipolar data bit |
| rd_clr | input | 1 | Host read strobe; clears the sticky interrupt bit |
| irq_mask | input | 1 | 1 blocks violations from setting the interrupt bit |
| pdv_status | output | 1 | Inverts on every violation |
| pdv_irq | output | 1 | Sticky interrupt bit |

## Verification
Both outputs are registered. Their response to a bit appears on the clock edge that samples it with `bit_en` high, so the latency is zero cycles after that edge. A read strobe clears `pdv_irq` on the edge that samples the strobe.

The bench drives inputs on the falling edge. It advances a behavioural model (a bit queue, a run count and a fill count) at the following rising edge. At the next falling edge it compares both outputs against the model, so every output is checked once per clock.

// File: rtl/pdv_pkg.sv
package pdv_pkg;
  // number of history bits needed for the largest window
  function automatic int hist_bits(input int blk, input int nmax);
    return blk * (nmax + 1);
  endfunction

  // width that can hold values 0..v
  function automatic int cnt_width(input int v);
    return $clog2(v + 1);
  endfunction
endpackage

// File: rtl/pdv_run_ctr.sv
module pdv_run_ctr #(
  parameter int RUN_LEN = 16
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  input  logic rearm,
  output logic run_hit
);
  localparam int RW = pdv_pkg::cnt_width(RUN_LEN);

  logic [RW-1:0] run_q;

  always_comb begin
    run_hit = bit_en && !bit_in && (run_q == RW'(RUN_LEN - 1));
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      run_q <= '0;
    end else if (bit_en) begin
      if (rearm || bit_in) run_q <= '0;
      else                 run_q <= run_q + 1'b1;
    end
  end

  // R1
  run_bound_chk: assert property (@(posedge clk) disable iff (rst)
    run_q < RW'(RUN_LEN));

  // R1
  run_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && bit_in) |=> (run_q == '0));
endmodule

// File: rtl/pdv_window.sv
module pdv_window #(
  parameter int BLK  = 8,
  parameter int NMAX = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  input  logic rearm,
  output logic win_hit
);
  localparam int HIST = pdv_pkg::hist_bits(BLK, NMAX);
  localparam int CW   = pdv_pkg::cnt_width(HIST);

  logic [HIST-1:0] hist_q;
  logic [CW-1:0]   fill_q;
  logic [CW-1:0]   fill_nx;
  logic [NMAX-1:0] hit_vec;

  always_comb begin
    fill_nx = (fill_q == CW'(HIST)) ? fill_q : fill_q + 1'b1;
    win_hit = bit_en && (|hit_vec);
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      hist_q <= '0;
      fill_q <= '0;
    end else if (bit_en) begin
      hist_q <= {hist_q[HIST-2:0], bit_in};
      fill_q <= rearm ? '0 : fill_nx;
    end
  end

  for (genvar n = 1; n <= NMAX; n++) begin : g_win
    localparam int L = BLK * (n + 1);
    logic [CW-1:0] cnt_q;
    logic [CW-1:0] cnt_nx;

    always_comb begin
      cnt_nx = cnt_q + CW'(bit_in) - CW'(hist_q[L-1]);
      hit_vec[n-1] = (fill_nx >= CW'(L)) && (cnt_nx < CW'(n));
    end

    always_ff @(posedge clk) begin
      if (rst)         cnt_q <= '0;
      else if (bit_en) cnt_q <= cnt_nx;
    end

    // R2
    win_cnt_chk: assert property (@(posedge clk) disable iff (rst)
      cnt_q <= CW'(L));
  end

  // R2
  fill_bound_chk: assert property (@(posedge clk) disable iff (rst)
    fill_q <= CW'(HIST));

  // R7
  fill_rearm_chk: assert property (@(posedge clk) disable iff (rst)
    (bit_en && rearm) |=> (fill_q == '0));
endmodule

// File: rtl/pdv_report.sv
module pdv_report (
  input  logic clk,
  input  logic rst,
  input  logic viol,
  input  logic rd_clr,
  input  logic irq_mask,
  output logic status_q,
  output logic flag_q
);
  logic set_flag;

  always_comb begin
    set_flag = viol && !irq_mask;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      status_q <= 1'b0;
      flag_q   <= 1'b0;
    end else begin
      status_q <= status_q ^ viol;
      if (set_flag)    flag_q <= 1'b1;
      else if (rd_clr) flag_q <= 1'b0;
    end
  end

  // R3
  status_hold_chk: assert property (@(posedge clk) disable iff (rst)
    !viol |=> $stable(status_q));

  // R3
  status_flip_chk: assert property (@(posedge clk) disable iff (rst)
    viol |=> (status_q != $past(status_q)));

  // R6
  flag_set_chk: assert property (@(posedge clk) disable iff (rst)
    (viol && !irq_mask) |=> flag_q);

  // R5
  mask_block_chk: assert property (@(posedge clk) disable iff (rst)
    (!flag_q && (!viol || irq_mask)) |=> !flag_q);

  // R4
  flag_clear_chk: assert property (@(posedge clk) disable iff (rst)
    (rd_clr && (!viol || irq_mask)) |=> !flag_q);
endmodule

// File: rtl/pdv_monitor.sv
module pdv_monitor #(
  parameter int RUN_LEN = 16,
  parameter int BLK     = 8,
  parameter int NMAX    = 23
) (
  input  logic clk,
  input  logic rst,
  input  logic bit_en,
  input  logic bit_in,
  input  logic rd_clr,
  input  logic irq_mask,
  output logic pdv_status,
  output logic pdv_irq
);
  logic run_hit;
  logic win_hit;
  logic viol;

  always_comb begin
    viol = run_hit || win_hit;
  end

  pdv_run_ctr #(.RUN_LEN(RUN_LEN)) run_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .rearm(viol), .run_hit(run_hit)
  );

  pdv_window #(.BLK(BLK), .NMAX(NMAX)) win_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .rearm(viol), .win_hit(win_hit)
  );

  pdv_report rep_i (
    .clk(clk), .rst(rst), .viol(viol), .rd_clr(rd_clr),
    .irq_mask(irq_mask), .status_q(pdv_status), .flag_q(pdv_irq)
  );

  // R9
  idle_stable_chk: assert property (@(posedge clk) disable iff (rst)
    !bit_en |=> $stable(pdv_status));
endmodule

// File: tb/pdv_monitor_tb_top.sv
`timescale 1ns/1ps
module pdv_monitor_tb_top;
  logic clk = 1'b0;
  logic rst = 1'b1;
  logic bit_en = 1'b0;
  logic bit_in = 1'b0;
  logic rd_clr = 1'b0;
  logic irq_mask = 1'b0;
  logic pdv_status;
  logic pdv_irq;

  int checks = 0;
  int fails = 0;

  // reference model state
  bit m_q[$];
  int m_fill = 0;
  int m_run = 0;
  bit m_status = 1'b0;
  bit m_irq = 1'b0;
  logic [15:0] lfsr = 16'hACE1;

  always #2 clk = ~clk;

  pdv_monitor dut_i (
    .clk(clk), .rst(rst), .bit_en(bit_en), .bit_in(bit_in),
    .rd_clr(rd_clr), .irq_mask(irq_mask),
    .pdv_status(pdv_status), .pdv_irq(pdv_irq)
  );

  task automatic compare(input string tag);
    checks++;
    if (pdv_status !== m_status) begin
      fails++;
      $display("FAIL %s pdv_status actual=%b expected=%b t=%0t", tag, pdv_status, m_status, $time);
    end
    checks++;
    if (pdv_irq !== m_irq) begin
      fails++;
      $display("FAIL %s pdv_irq actual=%b expected=%b t=%0t", tag, pdv_irq, m_irq, $time);
    end
  endtask

  task automatic model_step(input bit en, input bit b, input bit rd, input bit mk);
    bit v;
    v = 1'b0;
    if (en) begin
      m_q.push_front(b);
      if (m_q.size() > 192) void'(m_q.pop_back());
      m_run = b ? 0 : m_run + 1;
      m_fill = (m_fill < 192) ? m_fill + 1 : 192;
      if (m_run >= 16) v = 1'b1;
      for (int n = 1; n <= 23; n++) begin
        int len;
        int ones;
        len = 8 * (n + 1);
        ones = 0;
        if (m_fill >= len) begin
          for (int i = 0; i < len; i++) ones += m_q[i];
          if (ones < n) v = 1'b1;
        end
      end
      if (v) begin
        m_run = 0;
        m_fill = 0;
      end
    end
    if (v) m_status = ~m_status;
    if (v && !mk) m_irq = 1'b1;
    else if (rd) m_irq = 1'b0;
  endtask

  task automatic drive(input bit en, input bit b, input bit rd, input bit mk, input string tag);
    bit_en = en;
    bit_in = b;
    rd_clr = rd;
    irq_mask = mk;
    @(posedge clk);
    model_step(en, b, rd, mk);
    @(negedge clk);
    compare(tag);
  endtask

  function automatic bit next_rand();
    lfsr = {lfsr[14:0], lfsr[15] ^ lfsr[13] ^ lfsr[12] ^ lfsr[10]};
    return lfsr[0];
  endfunction

  initial begin
    #800000;
    fails++;
    $display("FAIL watchdog expired");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    // R8 reset state
    rst = 1'b1;
    repeat (3) @(negedge clk);
    rst = 1'b0;
    compare("R8");
    // R8: no violation before 16th bit
    for (int i = 0; i < 15; i++) drive(1, 0, 0, 0, "R8");
    // R1: 16th zero flags
    drive(1, 0, 0, 0, "R1");
    // R9: idle cycles with changing data
    for (int i = 0; i < 12; i++) drive(0, i[0], 0, 0, "R9");
    // R4: read clears sticky bit
    drive(0, 0, 1, 0, "R4");
    drive(0, 0, 0, 0, "R4");
    // R7: continuous zeros re-flag every 16 bits
    for (int i = 0; i < 48; i++) drive(1, 0, 0, 0, "R7");
    // R6: read collides with violation
    drive(0, 0, 1, 0, "R6");
    for (int i = 0; i < 15; i++) drive(1, 0, 0, 0, "R6");
    drive(1, 0, 1, 0, "R6");
    drive(0, 0, 0, 0, "R6");
    // R5: mask blocks sticky bit
    drive(0, 0, 1, 1, "R5");
    for (int i = 0; i < 16; i++) drive(1, 0, 0, 1, "R5");
    for (int i = 0; i < 16; i++) drive(1, 0, 1, 1, "R5");
    drive(0, 0, 1, 0, "R5");
    // R2: one in eight (no violation), then sparser patterns
    for (int i = 0; i < 400; i++) drive(1, (i % 8) == 0, 0, 0, "R2");
    for (int i = 0; i < 600; i++) drive(1, (i % 9) == 0, 0, 0, "R2");
    for (int i = 0; i < 400; i++) drive(1, (i % 15) == 0, i % 50 == 0, 0, "R2");
    for (int i = 0; i < 300; i++) drive(1, 1, 0, 0, "R2");
    for (int i = 0; i < 2000; i++) begin
      bit a;
      bit c;
      a = next_rand();
      c = next_rand();
      drive(1, a & c & next_rand(), (i % 97) == 0, 0, "R2");
    end
    // R3: gated enables with random data and mask
    for (int i = 0; i < 3000; i++) begin
      bit e;
      bit d;
      e = next_rand();
      d = next_rand() & next_rand();
      drive(e, d, (i % 41) == 0, (i % 300) > 250, "R3");
    end
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule